// File: doc/BRIEF.md
# Rotate-and-Mask Bit Field Merger

This block merges two data words under a generated field mask, all in one combinational pass. The first operand, M, can be rotated left by a count. The second operand, A, fills every bit position that the mask leaves clear. The mask is a contiguous run of ones, with its width given by a width code. It either sits at bit 0 of the word or is rotated left by the same count. Two control bits choose among four operations:

- field extract: rotate M, keep the mask at the bottom;
- field insert: rotate both M and the mask;
- masked insert: rotate only the mask;
- plain bottom-masked merge: rotate neither.

The mask is not produced by a shifter. It is the combination of two edge patterns, each taken from a table indexed by a bit position. One table sets every bit up to and including the upper edge. The other sets every bit from the lower edge upward. An optional output register holds the result for timing closure.

Top module: `bitfield_merge`

## Requirements
- R1: When `src_rot`=1, M is rotated left by `rot_cnt` (0 to 31) as a true rotation: bits leaving bit 31 re-enter at bit 0.
- R2: Every result bit equals the (possibly rotated) M bit where the mask is 1, and the A bit where the mask is 0.
- R3: With `mask_rot`=0 and `src_rot`=1 (field extract), the mask occupies bits 0 up to width-1 while M is rotated.
- R4: With `mask_rot`=1 and `src_rot`=1 (field insert), the mask starts at bit `rot_cnt`, so the low-order bits of M replace that field of A.
- R5: With `mask_rot`=1 and `src_rot`=0 (masked insert), M is used unrotated and the mask starts at bit `rot_cnt`.
- R6: With `mask_rot`=0 and `src_rot`=0, unrotated M is merged through a mask that starts at bit 0.
- R7: The field width is `wid_m1`+1, giving 1 to 32 bits. Code 31 selects the full word, so A has no effect on the result.
- R8: When `mask_rot`=1 and `rot_cnt`+width exceeds 32, the field wraps: its upper part continues from bit 0.
- R9: With `OUT_REG`=1 the result appears one clock after the operands are applied, and it is zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset that clears the output register |
| m_src | input | 32 | Operand that is rotated and placed into the field |
| a_src | input | 32 | Operand that supplies the bits outside the field |
| rot_cnt | input | 5 | Left rotation count for M and for the mask |
| wid_m1 | input | 5 | Field width minus one |
| mask_rot | input | 1 | 1 = rotate the mask by `rot_cnt` |
| src_rot | input | 1 | 1 = rotate M by `rot_cnt` |
| result | output | 32 | Merged word |

## Verification
The bench instantiates the block with `DATA_W`=32 and `OUT_REG`=1. With these values every field position and width of a real word is in range, including wrapped fields and the full-word width. The registered output also makes the one-cycle latency and the reset value observable. Directed vectors cover each of the four control combinations, rotation counts 0 and 31, and wrapped fields. A block of pseudo-random vectors is then compared against a shift-based reference model.

// File: rtl/bitfield_merge.sv
module bitfield_merge #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] m_src,
  input  logic [DATA_W-1:0] a_src,
  input  logic [CNT_W-1:0]  rot_cnt,
  input  logic [CNT_W-1:0]  wid_m1,
  input  logic              mask_rot,
  input  logic              src_rot,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0]   upto_tab [DATA_W];
  logic [DATA_W-1:0]   from_tab [DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_edge
    assign upto_tab[i] = {DATA_W{1'b1}} >> (DATA_W - 1 - i);
    assign from_tab[i] = {DATA_W{1'b1}} << i;
  end

  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   m_eff;
  logic [CNT_W-1:0]    lo_edge, hi_edge;
  logic                wraps;
  logic [DATA_W-1:0]   fmask;
  logic [DATA_W-1:0]   merged;

  assign dbl     = {m_src, m_src} << rot_cnt;
  assign m_eff   = src_rot ? dbl[2*DATA_W-1:DATA_W] : m_src;

  assign lo_edge = mask_rot ? rot_cnt : '0;
  assign hi_edge = lo_edge + wid_m1;
  assign wraps   = hi_edge < lo_edge;
  assign fmask   = wraps ? (upto_tab[hi_edge] | from_tab[lo_edge])
                         : (upto_tab[hi_edge] & from_tab[lo_edge]);

  assign merged  = (m_eff & fmask) | (a_src & ~fmask);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) result <= '0;
      else        result <= merged;
  end else begin : g_comb
    assign result = merged;
  end

  assert_mask_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fmask) == int'(wid_m1) + 1);

  assert_mask_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_rot |-> fmask[0]);

  assert_mask_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rot |-> fmask[rot_cnt]);

  assert_mask_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rot && (int'(rot_cnt) + int'(wid_m1) >= DATA_W)) |-> (fmask[0] && fmask[DATA_W-1]));

  assert_same_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_rot && m_src == a_src) |-> merged == a_src);

endmodule

// File: tb/sim_bitfield_merge.sv
module sim_bitfield_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] m_src = '0, a_src = '0;
  logic [4:0]  rot_cnt = '0, wid_m1 = '0;
  logic        mask_rot = 1'b0, src_rot = 1'b0;
  logic [31:0] result;

  int checks = 0, fails = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  bitfield_merge #(.DATA_W(32), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .m_src(m_src), .a_src(a_src),
    .rot_cnt(rot_cnt), .wid_m1(wid_m1), .mask_rot(mask_rot),
    .src_rot(src_rot), .result(result));

  function automatic logic [31:0] rotl(logic [31:0] v, int r);
    return (r == 0) ? v : ((v << r) | (v >> (32 - r)));
  endfunction

  function automatic logic [31:0] model(logic [31:0] m, logic [31:0] a,
                                        int r, int wm1, bit mr, bit sr);
    logic [31:0] ms, mk;
    ms = sr ? rotl(m, r) : m;
    mk = (wm1 == 31) ? 32'hFFFF_FFFF : ((32'd1 << (wm1 + 1)) - 32'd1);
    if (mr) mk = rotl(mk, r);
    return (ms & mk) | (a & ~mk);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: result=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [31:0] m, logic [31:0] a,
                       int r, int wm1, bit mr, bit sr);
    @(negedge clk);
    m_src = m; a_src = a; rot_cnt = 5'(r); wid_m1 = 5'(wm1);
    mask_rot = mr; src_rot = sr;
    exp_q.push_back(model(m, a, r, wm1, mr, sr));
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), result, exp_q.pop_front());
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_src = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1 check("R9 reset clears output", result, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    drive("R1 rotate by 1 wraps top bit", 32'h8000_0001, 32'h0, 1, 31, 1'b0, 1'b1);
    drive("R1 rotate by 31", 32'h0000_0003, 32'h0, 31, 31, 1'b0, 1'b1);
    drive("R1 rotate by 0", 32'h1234_5678, 32'h0, 0, 31, 1'b0, 1'b1);
    drive("R3 extract byte", 32'h1234_5678, 32'hFFFF_FFFF, 8, 7, 1'b0, 1'b1);
    drive("R3 extract single bit", 32'h4000_0000, 32'h0, 2, 0, 1'b0, 1'b1);
    drive("R4 insert nibble", 32'h0000_000A, 32'hFFFF_FFFF, 12, 3, 1'b1, 1'b1);
    drive("R4 insert at top", 32'h0000_00FF, 32'h0, 24, 7, 1'b1, 1'b1);
    drive("R5 masked insert", 32'hAAAA_AAAA, 32'h5555_5555, 4, 15, 1'b1, 1'b0);
    drive("R5 masked insert count 0", 32'hFFFF_FFFF, 32'h0, 0, 9, 1'b1, 1'b0);
    drive("R6 plain bottom merge", 32'hCAFE_F00D, 32'h1111_1111, 9, 11, 1'b0, 1'b0);
    drive("R7 width code 31 ignores A", 32'h0F0F_0F0F, 32'hFFFF_FFFF, 13, 31, 1'b1, 1'b1);
    drive("R7 width code 31 ignores A plain", 32'h0000_0000, 32'hFFFF_FFFF, 5, 31, 1'b0, 1'b0);
    drive("R8 wrapped field", 32'h0000_000F, 32'h0, 30, 3, 1'b1, 1'b1);
    drive("R8 wrapped masked insert", 32'hFFFF_FFFF, 32'h0, 28, 9, 1'b1, 1'b0);
    drive("R2 outside field keeps A", 32'h0, 32'h9ABC_DEF0, 16, 3, 1'b1, 1'b1);

    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = k % 4;
      drive(sel == 0 ? "R3 random" : sel == 1 ? "R4 random" :
            sel == 2 ? "R5 random" : "R6 random",
            $urandom, $urandom, $urandom_range(31), $urandom_range(31),
            sel == 1 || sel == 2, sel == 0 || sel == 1);
    end

    @(negedge clk);
    m_src = 32'h1; a_src = 32'h0; rot_cnt = 5'd0; wid_m1 = 5'd31;
    mask_rot = 1'b0; src_rot = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    m_src = 32'h2;
    #1 check("R9 output holds until next edge", result, 32'h1);
    @(posedge clk);
    #1 check("R9 one-cycle latency", result, 32'h2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule